// File: doc/BRIEF.md
# Multiplexed-Address Synchronous DRAM Controller

This block sits between a processor and a synchronous DRAM whose address pins are shared between the row and column halves of the address. The processor raises a request with a complete word address and a read/write flag. The controller then places the high-order row field on the shared pins with a row strobe. After a fixed activation gap it places the low-order column field on the same pins with a column strobe. Reads are fixed-length bursts: the memory steps through the columns by itself, and the controller marks each returning word with a valid strobe. Writes are single words. The processor drives the data in the column-strobe cycle. Data lines run directly between processor and memory and never pass through this block.

An internal interval timer schedules row-only refresh cycles, and an internal counter supplies the rows they refresh. A refresh that is due only goes out while the processor is not requesting. Once its deadline arrives it takes precedence over a waiting request. All state changes on the rising clock edge, and the reset is synchronous and active high.

Top module: `sdc_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `rd_valid`, `mem_cs`, `mem_ras` and `mem_cas` are 0.
- R2: A request is accepted on a rising edge where `req` and `ready` are both 1. In the next cycle, `mem_ras` and `mem_cs` are 1 and `mem_addr` carries the row field `req_addr[20:9]`.
- R3: Exactly `ACT_DLY` (default 2) cycles after the row-strobe cycle, `mem_cas` and `mem_cs` are 1 and `mem_addr` carries the column field `req_addr[8:0]` zero-extended. Between the two strobe cycles every strobe is 0. `mem_ras` and `mem_cas` are never 1 together, and each strobe is always accompanied by `mem_cs`.
- R4: For a read, `mem_rw` is 1 in the column-strobe cycle. `rd_valid` is 1 for exactly `BURST` (default 4) consecutive cycles, starting `CAS_LAT` (default 3) cycles after the column strobe, so the first word arrives 5 cycles after the row strobe. No further column strobe is issued during the burst.
- R5: For a write, `mem_rw` is 0 in the column-strobe cycle and only one column strobe is issued. `ready` returns to 1 in the cycle after the column strobe.
- R6: The burst words seen by the processor are the memory words at the requested row and at column, column+1, column+2 and column+3 (modulo 512). Words written earlier through the controller are read back at the same addresses.
- R7: If the refresh interval has elapsed and no request is present, the controller issues a row-only refresh. This is a cycle with `mem_ras` and `mem_cs` at 1 and `mem_addr` equal to the refresh row, followed by no column strobe, with `ready` held at 0 for `REF_CYC` cycles. The refresh row starts at 0 and advances by one per refresh. With no requests present, consecutive refresh strobes are `REF_INT-REF_EARLY+1` cycles apart.
- R8: A refresh that is due but not yet at its deadline does not preempt requests. With `req` held high continuously, the next refresh strobe comes at least `REF_INT+1` cycles after the previous one and at most `ACT_DLY+CAS_LAT+BURST` cycles after that.
- R9: `ready` is 0 from the row strobe until the operation completes. A request raised and withdrawn while `ready` is 0 is never accepted and produces no row strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Processor request, held until accepted |
| req_we | input | 1 | 1 = single-word write, 0 = burst read |
| req_addr | input | 21 | Full word address: row in [20:9], column in [8:0] |
| ready | output | 1 | Controller can accept a request this cycle |
| rd_valid | output | 1 | A burst read word is on the data lines this cycle |
| mem_cs | output | 1 | Memory chip select, active high |
| mem_ras | output | 1 | Row strobe, active high |
| mem_cas | output | 1 | Column strobe, active high |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 12 | Multiplexed row/column address |

## Verification
Every result is due at a fixed cycle offset from the accepting edge. The row strobe comes one cycle after acceptance, the column strobe 2 cycles later, and the read words 3 to 6 cycles after the column strobe. Write completion is signalled the cycle after the column strobe, and a refresh releases `ready` 4 cycles after its strobe. The bench drives and samples on the falling edge. It steps one cycle at a time from the accepting edge and checks each output in exactly the cycle it is due, with no waiting window. The refresh spacing is measured against a free-running cycle counter and compared with the exact figure for the idle case, and with the bounded range when requests keep arriving.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ACT,
    S_CAS,
    S_LAT,
    S_BURST,
    S_REF
  } sdc_state_t;
endpackage

// File: rtl/sdc_addr_split.sv
module sdc_addr_split #(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int MA_W  = 12
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  output logic [MA_W-1:0]        row_f,
  output logic [MA_W-1:0]        col_f
);
  // Row is the high-order field, column the low-order field; both padded to pin width.
  always_comb begin
    row_f = '0;
    col_f = '0;
    row_f[ROW_W-1:0] = addr[ROW_W+COL_W-1:COL_W];
    col_f[COL_W-1:0] = addr[COL_W-1:0];
  end
endmodule

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
  parameter int REF_INT   = 512,
  parameter int REF_EARLY = 128,
  parameter int ROW_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  output logic             pend,
  output logic             urgent,
  output logic [ROW_W-1:0] row
);
  localparam int TW = $clog2(REF_INT + 1);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      row    <= '0;
    end else if (grant) begin
      tick_q <= '0;
      row    <= row + 1'b1;
    end else if (tick_q != TW'(REF_INT)) begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign pend   = (tick_q >= TW'(REF_INT - REF_EARLY));
  assign urgent = (tick_q == TW'(REF_INT));
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int ACT_DLY   = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST     = 4,
  parameter int REF_CYC   = 4,
  parameter int REF_INT   = 512,
  parameter int REF_EARLY = 128,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ready,
  output logic              rd_valid,
  output logic              mem_cs,
  output logic              mem_ras,
  output logic              mem_cas,
  output logic              mem_rw,
  output logic [MA_W-1:0]   mem_addr
);
  localparam int CW = $clog2(ACT_DLY + CAS_LAT + BURST + REF_CYC + 1);

  logic [MA_W-1:0]  row_f, col_f, col_q, ref_addr;
  logic [ROW_W-1:0] ref_row;
  logic             ref_pend, ref_urgent, ref_go, accept, we_q;
  sdc_state_t       state_q;
  logic [CW-1:0]    cnt_q;

  sdc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_split (
    .addr  (req_addr),
    .row_f (row_f),
    .col_f (col_f)
  );

  sdc_ref_timer #(.REF_INT(REF_INT), .REF_EARLY(REF_EARLY), .ROW_W(ROW_W)) u_ref (
    .clk    (clk),
    .rst    (rst),
    .grant  (ref_go),
    .pend   (ref_pend),
    .urgent (ref_urgent),
    .row    (ref_row)
  );

  always_comb begin
    ref_addr = '0;
    ref_addr[ROW_W-1:0] = ref_row;
  end

  // Refresh waits for a gap in requests unless its deadline has arrived.
  assign ready  = (state_q == S_IDLE) && !ref_urgent;
  assign ref_go = (state_q == S_IDLE) && ref_pend && (ref_urgent || !req);
  assign accept = ready && req && !ref_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      we_q     <= 1'b0;
      col_q    <= '0;
      mem_cs   <= 1'b0;
      mem_ras  <= 1'b0;
      mem_cas  <= 1'b0;
      mem_rw   <= 1'b1;
      mem_addr <= '0;
      rd_valid <= 1'b0;
    end else begin
      mem_cs  <= 1'b0;
      mem_ras <= 1'b0;
      mem_cas <= 1'b0;
      mem_rw  <= 1'b1;
      unique case (state_q)
        S_IDLE: begin
          if (ref_go) begin
            state_q  <= S_REF;
            mem_cs   <= 1'b1;
            mem_ras  <= 1'b1;
            mem_addr <= ref_addr;
            cnt_q    <= CW'(REF_CYC - 1);
          end else if (accept) begin
            state_q  <= S_ACT;
            mem_cs   <= 1'b1;
            mem_ras  <= 1'b1;
            mem_addr <= row_f;
            we_q     <= req_we;
            col_q    <= col_f;
            cnt_q    <= CW'(ACT_DLY - 1);
          end
        end
        S_ACT: begin
          if (cnt_q == '0) begin
            state_q  <= S_CAS;
            mem_cs   <= 1'b1;
            mem_cas  <= 1'b1;
            mem_rw   <= ~we_q;
            mem_addr <= col_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_CAS: begin
          if (we_q) begin
            state_q <= S_IDLE;
          end else begin
            state_q <= S_LAT;
            cnt_q   <= CW'(CAS_LAT - 2);
          end
        end
        S_LAT: begin
          if (cnt_q == '0) begin
            state_q  <= S_BURST;
            rd_valid <= 1'b1;
            cnt_q    <= CW'(BURST - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_BURST: begin
          if (cnt_q == '0) begin
            state_q  <= S_IDLE;
            rd_valid <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_REF: begin
          if (cnt_q == '0) state_q <= S_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_ctrl_chk.sv
module sdc_ctrl_chk #(
  parameter int ACT_DLY = 2,
  parameter int BURST   = 4
) (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic rd_valid,
  input logic mem_cs,
  input logic mem_ras,
  input logic mem_cas
);
  logic [7:0] since_ras;
  logic [7:0] vrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ras <= 8'hFF;
      vrun      <= '0;
    end else begin
      if (mem_ras)                since_ras <= '0;
      else if (since_ras != 8'hFF) since_ras <= since_ras + 1'b1;
      if (rd_valid) vrun <= vrun + 1'b1;
      else          vrun <= '0;
    end
  end

  a_r3_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(mem_ras && mem_cas));

  a_r3_strobe_selects: assert property (@(posedge clk) disable iff (rst)
    (mem_ras || mem_cas) |-> mem_cs);

  a_r3_cas_spacing: assert property (@(posedge clk) disable iff (rst)
    mem_cas |-> (since_ras == 8'(ACT_DLY - 1)));

  a_r4_burst_max: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (vrun < 8'(BURST)));

  a_r4_burst_full: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_valid) |-> (vrun == 8'(BURST)));

  a_r9_busy_in_burst: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !ready);
endmodule

bind sdc_ctrl sdc_ctrl_chk #(.ACT_DLY(ACT_DLY), .BURST(BURST)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ready    (ready),
  .rd_valid (rd_valid),
  .mem_cs   (mem_cs),
  .mem_ras  (mem_ras),
  .mem_cas  (mem_cas)
);

// File: tb/sdc_ctrl_tb.sv
`timescale 1ns/1ps
module sdc_ctrl_tb;
  localparam int ACT_DLY = 2, CAS_LAT = 3, BURST = 4, REF_CYC = 4;
  localparam int REF_INT = 512, REF_EARLY = 128;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, req_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic ready, rd_valid, mem_cs, mem_ras, mem_cas, mem_rw;
  logic [11:0] mem_addr;
  logic [7:0] wdata = '0, rdata = '0;
  int nchk = 0, nerr = 0, cyc = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  sdc_ctrl #(.ACT_DLY(ACT_DLY), .CAS_LAT(CAS_LAT), .BURST(BURST), .REF_CYC(REF_CYC),
             .REF_INT(REF_INT), .REF_EARLY(REF_EARLY)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .ready(ready), .rd_valid(rd_valid), .mem_cs(mem_cs), .mem_ras(mem_ras),
    .mem_cas(mem_cas), .mem_rw(mem_rw), .mem_addr(mem_addr));

  function automatic logic [7:0] dflt(int k);
    return 8'(k ^ (k >> 8) ^ (k >> 16) ^ 8'h5A);
  endfunction

  // Behavioural memory stub: latches row/column, bursts with internal column stepping.
  logic [7:0] smem [int];
  logic [11:0] s_row = '0, b_row = '0;
  logic [8:0]  b_col = '0;
  int s_lat = 0, s_beats = 0;
  always @(posedge clk) begin
    if (mem_cs && mem_ras) s_row <= mem_addr;
    if (mem_cs && mem_cas && !mem_rw) smem[{s_row, mem_addr[8:0]}] = wdata;
    if (mem_cs && mem_cas && mem_rw) begin
      b_row <= s_row; b_col <= mem_addr[8:0];
      s_lat <= CAS_LAT - 1; s_beats <= BURST;
    end else if (s_beats > 0) begin
      if (s_lat > 1) s_lat <= s_lat - 1;
      else begin
        rdata   <= smem.exists({b_row, b_col}) ? smem[{b_row, b_col}] : dflt({b_row, b_col});
        b_col   <= b_col + 1'b1;
        s_beats <= s_beats - 1;
      end
    end
  end

  logic [7:0] shadow [int];
  int ref_seen = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic launch(input logic [20:0] a, input logic we, input logic [7:0] d);
    step();
    while (!ready) step();
    req = 1'b1; req_we = we; req_addr = a; wdata = d;
    step();   // now in the row-strobe cycle
    req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    check(ready && !rd_valid && !mem_cs && !mem_ras && !mem_cas, "R1 reset state",
          {ready, rd_valid, mem_cs, mem_ras, mem_cas}, 5'b10000);
  endtask

  task automatic t_write(input logic [20:0] a, input logic [7:0] d);
    launch(a, 1'b1, d);
    check(mem_ras && mem_cs && !mem_cas && mem_addr == a[20:9], "R2 write row strobe",
          mem_addr, a[20:9]);
    for (int i = 1; i < ACT_DLY; i++) begin
      step();
      check(!mem_ras && !mem_cas, "R3 gap before column", {mem_ras, mem_cas}, 0);
    end
    step();
    check(mem_cas && mem_cs && !mem_rw && mem_addr == {3'b0, a[8:0]}, "R5 write column strobe",
          {mem_rw, mem_addr}, {1'b0, 3'b0, a[8:0]});
    step();
    check(ready && !mem_cas, "R5 ready after write", ready, 1);
    shadow[a] = d;
  endtask

  task automatic t_read(input logic [20:0] a, input bit poke);
    launch(a, 1'b0, 8'h00);
    check(mem_ras && mem_cs && mem_addr == a[20:9] && !ready, "R2 read row strobe",
          mem_addr, a[20:9]);
    for (int i = 1; i < ACT_DLY; i++) begin
      step();
      check(!mem_ras && !mem_cas && !ready, "R3 gap before column", {mem_ras, mem_cas}, 0);
    end
    step();
    check(mem_cas && mem_cs && !mem_ras && mem_rw && mem_addr == {3'b0, a[8:0]},
          "R3 read column strobe", {mem_rw, mem_addr}, {1'b1, 3'b0, a[8:0]});
    for (int i = 1; i < CAS_LAT; i++) begin
      step();
      if (poke && i == 1) begin req = 1'b1; req_we = 1'b0; req_addr = 21'h0F0F0F; end
      check(!rd_valid && !mem_cas, "R4 latency gap", rd_valid, 0);
    end
    for (int i = 0; i < BURST; i++) begin
      logic [20:0] wa;
      logic [7:0]  ex;
      step();
      wa = {a[20:9], 9'(a[8:0] + 9'(i))};
      ex = shadow.exists(wa) ? shadow[wa] : dflt(int'(wa));
      check(rd_valid && !mem_cas && !ready, "R4 burst beat valid", rd_valid, 1);
      check(rdata == ex, "R6 burst data", rdata, ex);
      if (poke && i == 1) req = 1'b0;
    end
    step();
    check(!rd_valid && ready, "R4 burst end", {rd_valid, ready}, 2'b01);
    if (poke) begin
      for (int i = 0; i < 4; i++) begin
        check(!mem_ras && ready, "R9 withdrawn request ignored", mem_ras, 0);
        step();
      end
    end
  endtask

  task automatic t_refresh_idle();
    int t1;
    req = 1'b0;
    for (int r = 0; r < 2; r++) begin
      int n = 0;
      step();
      while (!mem_ras && n < 1200) begin step(); n++; end
      check(mem_ras && mem_addr == 12'(ref_seen), "R7 refresh row", mem_addr, ref_seen);
      if (r == 1) check(cyc - t1 == REF_INT - REF_EARLY + 1, "R7 refresh spacing",
                        cyc - t1, REF_INT - REF_EARLY + 1);
      t1 = cyc;
      ref_seen++;
      for (int i = 1; i < REF_CYC; i++) begin
        step();
        check(!mem_cas && !mem_ras && !ready, "R7 refresh is row only", {mem_cas, ready}, 0);
      end
      step();
      check(ready, "R7 ready after refresh", ready, 1);
    end
  endtask

  task automatic t_refresh_urgent();
    int t0, n = 0, reads = 0;
    // Previous refresh strobe was REF_CYC cycles ago.
    t0 = cyc - REF_CYC;
    req = 1'b1; req_we = 1'b0; req_addr = {12'hABC, 9'h010};
    step();
    while (n < 1200 && !(mem_ras && mem_addr == 12'(ref_seen))) begin
      if (mem_ras && mem_addr == 12'hABC) reads++;
      step(); n++;
    end
    req = 1'b0;
    check(cyc - t0 >= REF_INT + 1 && cyc - t0 <= REF_INT + 1 + ACT_DLY + CAS_LAT + BURST,
          "R8 deadline refresh spacing", cyc - t0, REF_INT + 1);
    check(reads >= 40, "R8 due refresh did not preempt", reads, 40);
    ref_seen++;
    step();
    while (!ready) step();
  endtask

  initial begin
    t_reset();
    t_write(21'h0ABCD5, 8'h3C);
    t_write(21'h1FFFFF, 8'hA5);
    t_write(21'h000000, 8'h11);
    t_read(21'h0ABCD4, 1'b0);
    t_read(21'h1FFFFE, 1'b0);
    t_read(21'h000000, 1'b0);
    t_read(21'h123456, 1'b1);
    t_refresh_idle();
    t_refresh_urgent();
    t_read(21'h0ABCD5, 1'b0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule